// File: doc/BRIEF.md
# Transmit Collision and Deferral Statistics

This block sits beside a half-duplex-capable transmit MAC and turns the outcome report the MAC produces for each transmit attempt into a bank of statistics counters. Each report carries the bytes actually put on the wire (a fragment cut short by a collision included), the number of collisions the frame suffered, a late-collision flag, a first-attempt deferral flag, the destination class (multicast, broadcast), a PAUSE marker, and the frame's size class and FCS status. From these the block counts traffic, sorts frames into collision classes, keeps a running collision total and tallies size and FCS anomalies.

The block also watches how long a ready frame waits for the medium. A byte-time timer runs while a frame is ready and has not started. When the wait exceeds the limit (3036 byte times by default), the block raises a one-cycle abort request to the MAC and counts an excessive deferral.

Every counter has a carry flag that latches when the counter wraps, and a mask bit that keeps that carry off the interrupt line. Counters, carry flags and masks are read and written through a simple word-addressed register port with a combinational read path.

Top module: `tcs_tx_stats`

## Requirements
- R1: After reset every counter reads 0, the carry register (address 32) reads 0, the mask register (address 33) reads all ones in its low 17 bits, and `irq` and `defer_abort` are 0.
- R2: Every report (`ev_valid` high for one cycle) adds `ev_bytes` to the byte counter (address 0), aborted frames included. Every report whose collision count is below 16 adds 1 to the packet counter (address 1).
- R3: A collision count of exactly 1 adds 1 to the single-collision counter (address 7). A count of 2 to 15 adds 1 to the multiple-collision counter (address 8). A count of 16 or more adds 1 to the excessive-collision counter (address 10) and marks the frame aborted. A count of 0 touches none of the three, and no report touches more than one.
- R4: A report with `ev_late` high adds 1 to the late-collision counter (address 9), whatever its collision count.
- R5: Every report adds its collision count (0 to 31) to the total-collision counter (address 11).
- R6: A report with `ev_deferred` high adds 1 to the deferred counter (address 5), aborted frames included.
- R7: While `frame_ready` is high and `tx_start` is low, each `byte_tick` advances a wait timer. The tick that takes the wait past DEFER_LIMIT (the 3037th by default) makes `defer_abort` high for exactly one cycle on the following cycle, and the excessive-deferral counter (address 6) then adds 1. The timer clears, and re-arms, when `frame_ready` is low or `tx_start` is high.
- R8: On a non-aborted report, `ev_bcast` adds 1 to the broadcast counter (address 3). `ev_mcast` without `ev_bcast` adds 1 to the multicast counter (address 2). `ev_pause` adds 1 to the PAUSE counter (address 4). An aborted report changes none of these.
- R9: On a non-aborted report, `ev_size` selects the size class: 0 is valid size, 1 is under 64 bytes, 2 is oversize, and 3 is counted in no size class. The counters are: valid size with bad FCS (address 14), oversize with good FCS (12), oversize with bad FCS (13), under 64 bytes with good FCS (15), and under 64 bytes with bad FCS (16). A valid-size frame with good FCS adds to none of them.
- R10: When counter i wraps past its all-ones value, carry bit i (address 32, bit i) becomes 1. Writing 1 to a carry bit clears it. Writing 0 leaves it unchanged. A wrap in the same cycle as the clear leaves the bit set.
- R11: `irq` is high exactly when some carry bit is 1 while its mask bit (address 33, bit i) is 0.
- R12: Counter i is at address i (0 to 16). A write loads the low CNT_W bits of `reg_wdata` into that counter. A write and an event in the same cycle leave the written value. Reads of any address are combinational on `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | One-cycle strobe: a transmit outcome report is present |
| ev_bytes | input | BYTE_W | Bytes sent for this report, fragments included |
| ev_coll | input | COLL_W | Number of collisions the frame experienced |
| ev_late | input | 1 | A late collision occurred |
| ev_mcast | input | 1 | Destination is multicast |
| ev_bcast | input | 1 | Destination is broadcast |
| ev_pause | input | 1 | The frame was a PAUSE control frame |
| ev_deferred | input | 1 | The frame deferred on its first attempt |
| ev_fcs_bad | input | 1 | The FCS was incorrect |
| ev_size | input | 2 | Size class: 0 valid, 1 under 64 bytes, 2 oversize, 3 none |
| frame_ready | input | 1 | A frame is waiting to transmit |
| tx_start | input | 1 | The waiting frame starts transmitting |
| byte_tick | input | 1 | One pulse per byte time |
| defer_abort | output | 1 | One-cycle request to abort the waiting frame for excessive deferral |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| irq | output | 1 | An unmasked carry flag is set |

## Verification
The excessive-deferral path is the hardest situation to reach from the ports, because the wait must run more than three thousand byte times with no start in between. The bench holds `frame_ready` and `byte_tick` high for exactly the limit, checks that no abort has appeared yet, then gives one more tick and checks for the single-cycle pulse and the counter step. A second run inserts `tx_start` partway through and checks that the wait re-arms. Counter rollover is reached by preloading counters near all-ones through the register port instead of by streaming tens of thousands of frames. The same preload sets up the wrap-with-clear and write-with-event collisions.

// File: rtl/tcs_pkg.sv
// Shared constants for the transmit statistics block: counter slot
// indices (which are also their register addresses), size-class codes
// and the addresses of the carry and mask registers.
package tcs_pkg;
    localparam int NUM_CNT   = 17;
    localparam int IDX_BYTES = 0;
    localparam int IDX_PKTS  = 1;
    localparam int IDX_MCAST = 2;
    localparam int IDX_BCAST = 3;
    localparam int IDX_PAUSE = 4;
    localparam int IDX_DEFER = 5;
    localparam int IDX_XDEF  = 6;
    localparam int IDX_COL1  = 7;
    localparam int IDX_COLN  = 8;
    localparam int IDX_LATE  = 9;
    localparam int IDX_XCOL  = 10;
    localparam int IDX_TCOL  = 11;
    localparam int IDX_BIG_OK  = 12;
    localparam int IDX_BIG_BAD = 13;
    localparam int IDX_OK_BAD  = 14;
    localparam int IDX_RUNT_OK = 15;
    localparam int IDX_RUNT_BAD = 16;

    localparam int ADDR_CARRY = 32;
    localparam int ADDR_MASK  = 33;

    localparam logic [1:0] SZ_VALID = 2'd0;
    localparam logic [1:0] SZ_RUNT  = 2'd1;
    localparam logic [1:0] SZ_GIANT = 2'd2;
endpackage

// File: rtl/tcs_classify.sv
// Turns one transmit outcome report into per-counter increment amounts.
// Assumes at most one report per cycle and a collision count wide enough
// to hold EXCESS_COLL. Purely combinational apart from its assertions.
module tcs_classify
    import tcs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 12,
    parameter int COLL_W      = 5,
    parameter int EXCESS_COLL = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ev_valid,
    input  logic [BYTE_W-1:0]                ev_bytes,
    input  logic [COLL_W-1:0]                ev_coll,
    input  logic                             ev_late,
    input  logic                             ev_mcast,
    input  logic                             ev_bcast,
    input  logic                             ev_pause,
    input  logic                             ev_deferred,
    input  logic                             ev_fcs_bad,
    input  logic [1:0]                       ev_size,
    input  logic                             defer_abort,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    inc
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic aborted;

    // Purpose: frames reaching the collision limit are aborted ones.
    always_comb aborted = (ev_coll >= COLL_W'(EXCESS_COLL));

    // Purpose: build the increment of every counter for this cycle.
    always_comb begin
        inc = '0;
        if (ev_valid) begin
            inc[IDX_BYTES] = CNT_W'(ev_bytes);
            inc[IDX_TCOL]  = CNT_W'(ev_coll);
            if (ev_deferred) inc[IDX_DEFER] = ONE;
            if (ev_late)     inc[IDX_LATE]  = ONE;
            if (ev_coll == COLL_W'(1))      inc[IDX_COL1] = ONE;
            else if (aborted)               inc[IDX_XCOL] = ONE;
            else if (ev_coll != '0)         inc[IDX_COLN] = ONE;
            if (!aborted) begin
                inc[IDX_PKTS] = ONE;
                if (ev_bcast)      inc[IDX_BCAST] = ONE;
                else if (ev_mcast) inc[IDX_MCAST] = ONE;
                if (ev_pause)      inc[IDX_PAUSE] = ONE;
                case (ev_size)
                    SZ_VALID: if (ev_fcs_bad) inc[IDX_OK_BAD] = ONE;
                    SZ_RUNT:  if (ev_fcs_bad) inc[IDX_RUNT_BAD] = ONE;
                              else            inc[IDX_RUNT_OK]  = ONE;
                    SZ_GIANT: if (ev_fcs_bad) inc[IDX_BIG_BAD] = ONE;
                              else            inc[IDX_BIG_OK]  = ONE;
                    default: ;
                endcase
            end
        end
        if (defer_abort) inc[IDX_XDEF] = ONE;
    end

    // R3: collision classes never overlap within one report
    a_r3_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc[IDX_COL1] != '0, inc[IDX_COLN] != '0, inc[IDX_XCOL] != '0}));

    // R2: an aborted report never counts as a sent packet
    a_r2_abort_no_pkt: assert property (@(posedge clk) disable iff (!rst_n)
        (inc[IDX_XCOL] != '0) |-> (inc[IDX_PKTS] == '0));
endmodule

// File: rtl/tcs_defer_timer.sv
// Byte-time wait timer for a ready frame. Counts byte ticks while a frame
// is ready and not yet started. Once the wait exceeds LIMIT it issues a
// single abort pulse and then idles until the frame is withdrawn or starts.
module tcs_defer_timer #(
    parameter int LIMIT = 3036
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_ready,
    input  logic tx_start,
    input  logic byte_tick,
    output logic defer_abort
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] wait_q;
    logic          tripped_q;

    // Purpose: advance, clear or trip the wait timer and drive the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q      <= '0;
            tripped_q   <= 1'b0;
            defer_abort <= 1'b0;
        end else begin
            defer_abort <= 1'b0;
            if (!frame_ready || tx_start) begin
                wait_q    <= '0;
                tripped_q <= 1'b0;
            end else if (byte_tick && !tripped_q) begin
                if (wait_q == TW'(LIMIT)) begin
                    tripped_q   <= 1'b1;
                    defer_abort <= 1'b1;
                end else begin
                    wait_q <= wait_q + 1'b1;
                end
            end
        end
    end

    // R7: the abort request lasts exactly one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        defer_abort |=> !defer_abort);

    // R7: the timer never runs past its limit
    a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= TW'(LIMIT));

    // R7: a start clears the wait, so no abort follows it
    a_r7_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !defer_abort);
endmodule

// File: rtl/tcs_counter_cell.sv
// One statistics counter with its sticky carry flag. Adds an arbitrary
// increment each cycle and wraps modulo 2**CNT_W. A software load has
// priority over the increment and never sets the carry.
module tcs_counter_cell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             clr_carry,
    output logic [CNT_W-1:0] value,
    output logic             carry
);
    logic [CNT_W:0] sum;

    // Purpose: widened sum so the wrap shows up in the top bit.
    always_comb sum = {1'b0, value} + {1'b0, inc};

    // Purpose: load, accumulate and track carry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            carry <= 1'b0;
        end else begin
            if (wr_en)            value <= wr_data;
            else if (inc != '0)   value <= sum[CNT_W-1:0];
            if (!wr_en && inc != '0 && sum[CNT_W]) carry <= 1'b1;
            else if (clr_carry)                    carry <= 1'b0;
        end
    end

    // R10: a carry stays set until software clears it
    a_r10_carry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !clr_carry) |=> carry);

    // R12: a load shows the written value on the next cycle
    a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data)));
endmodule

// File: rtl/tcs_tx_stats.sv
// Transmit collision and deferral statistics. Classifies MAC outcome
// reports, runs the excessive-deferral timer and holds the counter bank,
// carry flags and masks behind a word-addressed register port.
// Assumes one report per cycle at most and DATA_W >= NUM_CNT, CNT_W.
module tcs_tx_stats
    import tcs_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BYTE_W      = 12,
    parameter int COLL_W      = 5,
    parameter int EXCESS_COLL = 16,
    parameter int DEFER_LIMIT = 3036,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [BYTE_W-1:0] ev_bytes,
    input  logic [COLL_W-1:0] ev_coll,
    input  logic              ev_late,
    input  logic              ev_mcast,
    input  logic              ev_bcast,
    input  logic              ev_pause,
    input  logic              ev_deferred,
    input  logic              ev_fcs_bad,
    input  logic [1:0]        ev_size,
    input  logic              frame_ready,
    input  logic              tx_start,
    input  logic              byte_tick,
    output logic              defer_abort,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic [NUM_CNT-1:0][CNT_W-1:0] inc_vec;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0]            carry_vec;
    logic [NUM_CNT-1:0]            mask_q;
    logic [NUM_CNT-1:0]            clr_vec;
    logic                          carry_wr;
    logic                          mask_wr;

    tcs_defer_timer #(.LIMIT(DEFER_LIMIT)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_ready (frame_ready),
        .tx_start    (tx_start),
        .byte_tick   (byte_tick),
        .defer_abort (defer_abort)
    );

    tcs_classify #(
        .CNT_W(CNT_W), .BYTE_W(BYTE_W), .COLL_W(COLL_W), .EXCESS_COLL(EXCESS_COLL)
    ) u_class (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_valid    (ev_valid),
        .ev_bytes    (ev_bytes),
        .ev_coll     (ev_coll),
        .ev_late     (ev_late),
        .ev_mcast    (ev_mcast),
        .ev_bcast    (ev_bcast),
        .ev_pause    (ev_pause),
        .ev_deferred (ev_deferred),
        .ev_fcs_bad  (ev_fcs_bad),
        .ev_size     (ev_size),
        .defer_abort (defer_abort),
        .inc         (inc_vec)
    );

    // Purpose: decode writes to the carry and mask registers.
    always_comb begin
        carry_wr = reg_we && (reg_addr == ADDR_W'(ADDR_CARRY));
        mask_wr  = reg_we && (reg_addr == ADDR_W'(ADDR_MASK));
        clr_vec  = carry_wr ? reg_wdata[NUM_CNT-1:0] : '0;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic wr_hit;
        always_comb wr_hit = reg_we && (reg_addr == ADDR_W'(i));
        tcs_counter_cell #(.CNT_W(CNT_W)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc       (inc_vec[i]),
            .wr_en     (wr_hit),
            .wr_data   (reg_wdata[CNT_W-1:0]),
            .clr_carry (clr_vec[i]),
            .value     (cnt_val[i]),
            .carry     (carry_vec[i])
        );
    end

    // Purpose: interrupt mask register, all masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= reg_wdata[NUM_CNT-1:0];
    end

    // Purpose: any unmasked carry raises the interrupt.
    always_comb irq = |(carry_vec & ~mask_q);

    // Purpose: combinational register read mux.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (reg_addr == ADDR_W'(i)) reg_rdata = DATA_W'(cnt_val[i]);
        end
        if (reg_addr == ADDR_W'(ADDR_CARRY)) reg_rdata = DATA_W'(carry_vec);
        if (reg_addr == ADDR_W'(ADDR_MASK))  reg_rdata = DATA_W'(mask_q);
    end

    // R11: a fully masked bank never interrupts
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq);

    // R2: the packet counter moves only on a report or a write to it
    a_r2_pkt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !(reg_we && reg_addr == ADDR_W'(IDX_PKTS)))
        |=> $stable(cnt_val[IDX_PKTS]));

    // R7: the excessive-deferral counter steps after an abort pulse
    a_r7_xdef_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (defer_abort && !(reg_we && reg_addr == ADDR_W'(IDX_XDEF)))
        |=> (cnt_val[IDX_XDEF] == $past(cnt_val[IDX_XDEF]) + CNT_W'(1)));
endmodule

// File: tb/tb_tcs_tx_stats.sv
// Vector-table bench for tcs_tx_stats with a reference model built
// from the requirements, followed by directed corner-case tests.
module tb_tcs_tx_stats;
    localparam int N = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [11:0] ev_bytes = '0;
    logic [4:0]  ev_coll = '0;
    logic        ev_late = 1'b0, ev_mcast = 1'b0, ev_bcast = 1'b0, ev_pause = 1'b0;
    logic        ev_deferred = 1'b0, ev_fcs_bad = 1'b0;
    logic [1:0]  ev_size = '0;
    logic        frame_ready = 1'b0, tx_start = 1'b0, byte_tick = 1'b0;
    logic        defer_abort;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [15:0] expv [N];

    always #5 clk = ~clk;

    tcs_tx_stats dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_bytes(ev_bytes),
        .ev_coll(ev_coll), .ev_late(ev_late), .ev_mcast(ev_mcast), .ev_bcast(ev_bcast),
        .ev_pause(ev_pause), .ev_deferred(ev_deferred), .ev_fcs_bad(ev_fcs_bad),
        .ev_size(ev_size), .frame_ready(frame_ready), .tx_start(tx_start),
        .byte_tick(byte_tick), .defer_abort(defer_abort), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [11:0] bytes;
        logic [4:0]  coll;
        logic        late, mc, bc, pause, dfr, bad;
        logic [1:0]  size;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{12'd64,   5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0},
        '{12'd100,  5'd1,  1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0},
        '{12'd512,  5'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0},
        '{12'd70,   5'd15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0},
        '{12'd40,   5'd16, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2},
        '{12'd60,   5'd0,  1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1},
        '{12'd50,   5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd1},
        '{12'd1600, 5'd2,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2},
        '{12'd1600, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2},
        '{12'd30,   5'd1,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3},
        '{12'd200,  5'd31, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd1}
    };

    function automatic string req_of(int i);
        case (i)
            0, 1:       return "R2";
            2, 3, 4:    return "R8";
            5:          return "R6";
            6:          return "R7";
            7, 8, 10:   return "R3";
            9:          return "R4";
            11:         return "R5";
            default:    return "R9";
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp_v);
        end
    endtask

    task automatic rd(int a, output logic [31:0] d);
        reg_addr = 6'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_addr = 6'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic model(vec_t v);
        expv[0]  += 16'(v.bytes);
        expv[11] += 16'(v.coll);
        if (v.dfr)  expv[5]++;
        if (v.late) expv[9]++;
        if (v.coll == 5'd1)       expv[7]++;
        else if (v.coll >= 5'd16) expv[10]++;
        else if (v.coll != 5'd0)  expv[8]++;
        if (v.coll < 5'd16) begin
            expv[1]++;
            if (v.bc)      expv[3]++;
            else if (v.mc) expv[2]++;
            if (v.pause)   expv[4]++;
            case (v.size)
                2'd0: if (v.bad) expv[14]++;
                2'd1: if (v.bad) expv[16]++; else expv[15]++;
                2'd2: if (v.bad) expv[13]++; else expv[12]++;
                default: ;
            endcase
        end
    endtask

    // drive one report for one cycle; counters are visible at the next negedge
    task automatic send(vec_t v);
        @(negedge clk);
        ev_valid = 1'b1; ev_bytes = v.bytes; ev_coll = v.coll; ev_late = v.late;
        ev_mcast = v.mc; ev_bcast = v.bc; ev_pause = v.pause; ev_deferred = v.dfr;
        ev_fcs_bad = v.bad; ev_size = v.size;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic compare_all(string tag);
        logic [31:0] d;
        for (int i = 0; i < N; i++) begin
            rd(i, d);
            check(req_of(i), $sformatf("%s counter %0d", tag, i), d, 32'(expv[i]));
        end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit seen;
        for (int i = 0; i < N; i++) expv[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        compare_all("R1 reset");
        rd(32, d); check("R1", "carry after reset", d, 32'h0);
        rd(33, d); check("R1", "mask after reset", d, 32'h1FFFF);
        check("R1", "irq after reset", 32'(irq), 32'h0);
        check("R1", "abort after reset", 32'(defer_abort), 32'h0);

        // main vector table
        for (int v = 0; v < NV; v++) begin
            send(VECS[v]);
            model(VECS[v]);
            compare_all($sformatf("vector %0d", v));
        end

        // R7: excessive deferral at the limit
        @(negedge clk);
        frame_ready = 1'b1; byte_tick = 1'b1;
        repeat (3036) @(negedge clk);
        check("R7", "no abort at limit", 32'(defer_abort), 32'h0);
        @(negedge clk);
        check("R7", "abort after limit", 32'(defer_abort), 32'h1);
        @(negedge clk);
        check("R7", "abort one cycle only", 32'(defer_abort), 32'h0);
        expv[6]++;
        rd(6, d); check("R7", "excessive deferral count", d, 32'(expv[6]));
        frame_ready = 1'b0;
        @(negedge clk);

        // R7: start re-arms the timer
        frame_ready = 1'b1;
        seen = 0;
        for (int k = 0; k < 6000; k++) begin
            tx_start = (k == 3000);
            @(negedge clk);
            if (defer_abort) seen = 1;
        end
        tx_start = 1'b0; frame_ready = 1'b0; byte_tick = 1'b0;
        check("R7", "start clears wait", 32'(seen), 32'h0);
        rd(6, d); check("R7", "no extra deferral count", d, 32'(expv[6]));

        // R10/R11: rollover, carry, mask, clear
        wr(0, 32'h0000FFF0);
        expv[0] = 16'hFFF0;
        send('{12'd32, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3});
        model('{12'd32, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3});
        rd(0, d);  check("R10", "byte counter wrapped", d, 32'h10);
        rd(32, d); check("R10", "carry bit 0 set", d, 32'h1);
        check("R11", "irq masked", 32'(irq), 32'h0);
        wr(33, 32'h1FFFE);
        check("R11", "irq unmasked", 32'(irq), 32'h1);
        wr(32, 32'h0);
        rd(32, d); check("R10", "write 0 keeps carry", d, 32'h1);
        wr(32, 32'h1);
        rd(32, d); check("R10", "write 1 clears carry", d, 32'h0);
        check("R11", "irq after clear", 32'(irq), 32'h0);

        // R10: wrap in the clear cycle keeps the carry
        wr(1, 32'h0000FFFF);
        @(negedge clk);
        ev_valid = 1'b1; ev_bytes = 12'd1; ev_coll = '0; ev_late = 0; ev_mcast = 0;
        ev_bcast = 0; ev_pause = 0; ev_deferred = 0; ev_fcs_bad = 0; ev_size = 2'd3;
        reg_addr = 6'd32; reg_wdata = 32'h2; reg_we = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; reg_we = 1'b0;
        expv[0] += 16'd1; expv[1] = 16'h0;
        rd(32, d); check("R10", "wrap beats clear", d, 32'h2);
        rd(1, d);  check("R2", "packet counter wrapped", d, 32'h0);

        // R12: write beats a same-cycle event
        @(negedge clk);
        ev_valid = 1'b1; ev_bytes = 12'd99;
        reg_addr = 6'd0; reg_wdata = 32'h1234; reg_we = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; reg_we = 1'b0;
        expv[0] = 16'h1234; expv[1]++;
        rd(0, d); check("R12", "write wins over event", d, 32'h1234);
        compare_all("R12 final");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule